// File: doc/BRIEF.md
# Ordered Multi-Event Trigger Combiner

This block turns single-cycle event pulses into trigger pulses. Event words come in groups of four, and each group is configured separately. Every word has a 4-bit mode code that sets its role:

- A word can be left unused.
- A word can complete a trigger when its own event arrives.
- A word can pass its progress up to the next higher-numbered word.

Relaying words therefore form chains that end at a completing word. The trigger for a chain fires only after every event in the chain has arrived in strictly increasing word order. Each arrival must come in a later cycle than the one before it.

Triggers in a group are numbered from the lowest completing word upward. The first chain drives trigger 0 of its group, the second drives trigger 1, and so on. The event pulses and trigger pulses are plain strobes with no valid/ready pairing. An event is offered for exactly one cycle and is either accepted or dropped. No back-pressure exists, so a trigger pulse that the downstream logic misses is not held. The mode codes are static configuration. Clear the progress with reset after changing them.

Top module: `tc_ordered_trigger`

## Requirements
- R1: Mode code 4'h1 makes a word complete a trigger and 4'h9 makes it relay. Code 4'h0 and every other code make the word unused, so its events have no effect.
- R2: A completing word whose lower neighbour is not relaying fires its trigger in the cycle after its event. It can fire on consecutive events with no gap.
- R3: A chain of relaying words ending at a completing word fires only when each word's event comes in a strictly later cycle than the event of the word below it. Events on two chain words in the same cycle advance the chain by at most one step.
- R4: An event on a chained word whose lower neighbour has not been accepted is ignored and does not advance the chain.
- R5: After a chain fires, all of its progress is cleared, so the complete ordered sequence is needed again.
- R6: Trigger k of a group (bit g*WORDS+k of trig_o) belongs to the (k+1)-th completing word counted from word 0 upward.
- R7: A group with no completing word never produces a trigger. Trigger outputs numbered at or above the count of completing words stay low.
- R8: Groups are independent: events and modes of one group never affect another group's triggers. Mode of word w in group g sits at mode_i[(g*WORDS+w)*4 +: 4], and its event at evt_i[g*WORDS+w].
- R9: A synchronous reset clears all chain progress and drives every trigger low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | GROUPS*WORDS | Event pulses, one per word |
| mode_i | input | GROUPS*WORDS*4 | Mode code per word |
| trig_o | output | GROUPS*WORDS | Trigger pulses, numbered per group |

## Verification
The directed patterns each target one ordering question:
- Correctly ordered events on a pair of words show that a chain fires.
- A higher word pulsed first shows that out-of-order events are dropped.
- Both words of a chain pulsed in one cycle show that a chain cannot advance two steps in a cycle.
- A repeated final event after a fire shows that progress is cleared.
- Mixed chain and standalone layouts, an all-unused group, and an undefined code show trigger numbering and group independence.

Long stretches of random pulses over four layouts are then compared every cycle against a behavioural chain-position model. These stretches expose mistakes in how far a chain advances per cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_FIRE  = 4'h1;
  localparam logic [CODE_W-1:0] CODE_RELAY = 4'h9;
endpackage

// File: rtl/tc_rank.sv
module tc_rank #(
  parameter int WORDS  = 4,
  parameter int RANK_W = 3
) (
  input  logic [WORDS-1:0]  is_fire,
  input  logic [WORDS-1:0]  fire,
  output logic [WORDS-1:0]  trig_next,
  output logic [RANK_W-1:0] n_term
);
  // Trigger number of each completing word = count of completing words below it.
  logic [RANK_W-1:0] cnt;
  always_comb begin
    cnt       = '0;
    trig_next = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (is_fire[i]) begin
        for (int k = 0; k < WORDS; k++) begin
          if (fire[i] && cnt == RANK_W'(k)) trig_next[k] = 1'b1;
        end
        cnt = cnt + RANK_W'(1);
      end
    end
    n_term = cnt;
  end
endmodule

// File: rtl/tc_group.sv
module tc_group
  import tc_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WORDS-1:0]        evt,
  input  logic [WORDS*CODE_W-1:0] mode,
  output logic [WORDS-1:0]        trig
);
  localparam int RANK_W = $clog2(WORDS + 1);

  logic [WORDS-1:0]  is_fire, is_relay, head, accept, fire, kill, armed, trig_next;
  logic [RANK_W-1:0] n_term;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign is_fire[i]  = mode[i*CODE_W +: CODE_W] == CODE_FIRE;
    assign is_relay[i] = mode[i*CODE_W +: CODE_W] == CODE_RELAY;
    if (i == 0) begin : g_low
      assign head[i]   = 1'b1;
      assign accept[i] = evt[i];
    end else begin : g_up
      assign head[i]   = !is_relay[i-1];
      assign accept[i] = evt[i] & (head[i] | armed[i-1]);
    end
    assign fire[i] = accept[i] & is_fire[i];
    if (i == WORDS-1) begin : g_top
      assign kill[i] = fire[i];
    end else begin : g_mid
      assign kill[i] = fire[i] | (is_relay[i] & kill[i+1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= '0;
    else     armed <= is_relay & ~kill & (accept | armed);
  end

  tc_rank #(.WORDS(WORDS), .RANK_W(RANK_W)) u_rank (
    .is_fire  (is_fire),
    .fire     (fire),
    .trig_next(trig_next),
    .n_term   (n_term)
  );

  always_ff @(posedge clk) begin
    if (rst) trig <= '0;
    else     trig <= trig_next;
  end

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (trig == '0 && armed == '0));

  for (genvar i = 0; i < WORDS; i++) begin : g_chk
    assert_no_excess_trig_R7: assert property (@(posedge clk) disable iff (rst)
      trig[i] |-> ($past(n_term) > RANK_W'(i)));
    assert_lone_fire_R2: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && is_fire[i] && head[i]) |=> (trig != '0));
    if (i > 0) begin : g_pair
      assert_out_of_order_R4: assert property (@(posedge clk) disable iff (rst)
        (evt[i] && is_relay[i] && is_relay[i-1] && !armed[i-1] && !armed[i]) |=> !armed[i]);
      assert_progress_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (fire[i] && is_relay[i-1]) |=> !armed[i-1]);
    end
  end
endmodule

// File: rtl/tc_ordered_trigger.sv
module tc_ordered_trigger
  import tc_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int WORDS  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [GROUPS*WORDS-1:0]        evt_i,
  input  logic [GROUPS*WORDS*CODE_W-1:0] mode_i,
  output logic [GROUPS*WORDS-1:0]        trig_o
);
  localparam int GRP_MODE_W = WORDS * CODE_W;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    tc_group #(.WORDS(WORDS)) u_grp (
      .clk (clk),
      .rst (rst),
      .evt (evt_i[g*WORDS +: WORDS]),
      .mode(mode_i[g*GRP_MODE_W +: GRP_MODE_W]),
      .trig(trig_o[g*WORDS +: WORDS])
    );
  end
endmodule

// File: tb/sim_tc_ordered_trigger.sv
module sim_tc_ordered_trigger;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_i = '0;
  logic [31:0] mode_i;
  logic [7:0] trig_o;
  logic [3:0] md [2][4];

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R9";
  int   prog [2][4];
  logic [7:0] exp_q = '0;

  always #2 clk = ~clk;

  always_comb
    for (int g = 0; g < 2; g++)
      for (int w = 0; w < 4; w++)
        mode_i[(g*4+w)*4 +: 4] = md[g][w];

  tc_ordered_trigger #(.GROUPS(2), .WORDS(4)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .mode_i(mode_i), .trig_o(trig_o));

  // Behavioural model: each chain tracks how many of its words were hit in order.
  always @(posedge clk) begin
    logic [7:0] nxt;
    nxt = '0;
    if (rst) begin
      for (int g = 0; g < 2; g++) for (int w = 0; w < 4; w++) prog[g][w] = 0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        int s, t;
        s = 0; t = 0;
        for (int w = 0; w < 4; w++) begin
          if (md[g][w] == 4'h1) begin
            if (evt_i[g*4 + s + prog[g][w]]) begin
              prog[g][w]++;
              if (prog[g][w] == w - s + 1) begin
                nxt[g*4+t] = 1'b1;
                prog[g][w] = 0;
              end
            end
            t++;
            s = w + 1;
          end else if (md[g][w] != 4'h9) begin
            s = w + 1;
          end
        end
      end
    end
    exp_q = nxt;
  end

  always @(negedge clk) begin
    n_run++;
    if (trig_o !== exp_q) begin
      n_fail++;
      $display("FAIL %s model compare: trig_o=%h expected %h", cur_req, trig_o, exp_q);
    end
  end

  task automatic check(input logic [7:0] e, input string req);
    n_run++;
    if (trig_o !== e) begin
      n_fail++;
      $display("FAIL %s directed: trig_o=%h expected %h", req, trig_o, e);
    end
  endtask

  task automatic step(input logic [7:0] ev, input logic [7:0] e, input string req);
    cur_req = req;
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
    check(e, req);
  endtask

  task automatic cfg(input int g, input logic [3:0] c3, c2, c1, c0);
    md[g][3] = c3; md[g][2] = c2; md[g][1] = c1; md[g][0] = c0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(8'h00, "R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    cfg(0, 4'h0, 4'h0, 4'h0, 4'h0);
    cfg(1, 4'h0, 4'h0, 4'h0, 4'h0);
    repeat (2) @(negedge clk);
    do_reset();

    // R3 / R6: chain on words 0-1, standalone words 2 and 3
    cfg(0, 4'h1, 4'h1, 4'h1, 4'h9);
    do_reset();
    step(8'h01, 8'h00, "R3");
    step(8'h02, 8'h01, "R3");
    step(8'h04, 8'h02, "R6");
    step(8'h08, 8'h04, "R6");
    // R4: higher word first is dropped
    step(8'h02, 8'h00, "R4");
    step(8'h01, 8'h00, "R4");
    step(8'h02, 8'h01, "R4");
    // R3: both chain words in one cycle advance a single step
    step(8'h03, 8'h00, "R3");
    step(8'h02, 8'h01, "R3");

    // R5: full four-word chain, then final word alone again
    cfg(0, 4'h1, 4'h9, 4'h9, 4'h9);
    do_reset();
    step(8'h01, 8'h00, "R5");
    step(8'h02, 8'h00, "R5");
    step(8'h04, 8'h00, "R5");
    step(8'h08, 8'h01, "R5");
    step(8'h08, 8'h00, "R5");
    step(8'h04, 8'h00, "R5");

    // R2: standalone words fire on back-to-back events
    cfg(0, 4'h1, 4'h1, 4'h1, 4'h1);
    do_reset();
    step(8'h0F, 8'h0F, "R2");
    step(8'h05, 8'h05, "R2");

    // R7 / R8: group 0 all unused, group 1 two pairs
    cfg(0, 4'h0, 4'h0, 4'h0, 4'h0);
    cfg(1, 4'h1, 4'h9, 4'h1, 4'h9);
    do_reset();
    step(8'h0F, 8'h00, "R7");
    step(8'h50, 8'h00, "R8");
    step(8'hAF, 8'h30, "R8");

    // R1: undefined code behaves as unused
    cfg(1, 4'h0, 4'h0, 4'h1, 4'h5);
    do_reset();
    step(8'h10, 8'h00, "R1");
    step(8'h20, 8'h10, "R1");

    // R9: reset in the middle of a chain
    cfg(0, 4'h0, 4'h0, 4'h1, 4'h9);
    do_reset();
    step(8'h01, 8'h00, "R9");
    do_reset();
    step(8'h02, 8'h00, "R9");
    step(8'h01, 8'h00, "R9");
    step(8'h02, 8'h01, "R9");

    // Random pulses over several layouts, compared to the model each cycle
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: begin cfg(0, 4'h1, 4'h9, 4'h9, 4'h9); cfg(1, 4'h1, 4'h9, 4'h1, 4'h9); end
        1: begin cfg(0, 4'h1, 4'h1, 4'h1, 4'h9); cfg(1, 4'h1, 4'h1, 4'h9, 4'h9); end
        2: begin cfg(0, 4'h9, 4'h1, 4'h0, 4'h1); cfg(1, 4'h1, 4'h0, 4'h9, 4'h1); end
        default: begin cfg(0, 4'h1, 4'h9, 4'h3, 4'h9); cfg(1, 4'h1, 4'h1, 4'h1, 4'h1); end
      endcase
      do_reset();
      cur_req = "R6";
      for (int n = 0; n < 1500; n++) begin
        evt_i = 8'($urandom) & 8'($urandom);
        @(negedge clk);
      end
      evt_i = '0;
      @(negedge clk);
    end

    finish_run();
  end
endmodule